// File: doc/BRIEF.md
# Cascadable Serial-Loaded LED Sink Controller

This block turns a serial bit stream into twenty-four on/off commands for open-drain LED sink channels. A controller clocks data in over a serial clock and data pair. The bits pass through a twenty-four stage shift register and then through a level-controlled hold stage to the channel outputs. The last stage also drives a serial output, retimed on the falling serial clock edge, so that the next device in a chain can take the data. A global active-low enable, an undervoltage flag and an overtemperature flag each turn every channel off without disturbing what is stored.

All control inputs are sampled on one system clock. The serial clock is oversampled, and its rising and falling transitions become single-cycle events inside the block. An active-low reset clears the shift register, the hold stage and the serial output at once. It is released through a short synchronizer, so the first shift after release lands on a known clock.

Top module: `led_sink_ctrl`

## Requirements
- R1: On each rising transition of `ser_clk` the value on `ser_din` is written into stage 1, and every stage k (k < 24) moves into stage k+1. The system clock edge that detects the rise performs the shift.
- R2: `ser_out` carries the content of stage 24 and changes only on the system clock edge that detects a falling transition of `ser_clk`. A rise of `ser_clk` leaves it unchanged.
- R3: While `latch_in` is 1, the channel word follows the shift register. While `latch_in` is 0, it keeps the value it had when `latch_in` fell, however many shifts take place.
- R4: While `en_n` is 1, all bits of `chan_on` are 0. While `en_n` is 0, they equal the channel word.
- R5: While `rst_n` is 0, `chan_on` and `ser_out` are 0 and the stored data is cleared. After `rst_n` rises, a wait of two system clocks is followed by normal shifting, and the first shifted bit lands in stage 1.
- R6: While `uv_flag` is 1, all channels are 0. Stored and held data are unaffected, so the previous pattern returns when the flag drops.
- R7: While `ot_flag` is 1, all channels are 0. Stored and held data are unaffected, so the previous pattern returns when the flag drops.
- R8: Two instances chained `ser_out` to `ser_din` act as one 48-stage register. After 48 bit periods the first device holds the last 24 bits and the second device holds the first 24 bits.
- R9: A stored 1 means the sink is on. Stage n drives `chan_on[n-1]`, so stage 1 is bit 0 and stage 24 is bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ser_clk | input | 1 | Serial clock, oversampled |
| ser_din | input | 1 | Serial data into stage 1 |
| latch_in | input | 1 | 1: channel word transparent; 0: hold |
| en_n | input | 1 | Active-low global channel enable |
| uv_flag | input | 1 | Supply undervoltage indication, forces all channels off |
| ot_flag | input | 1 | Overtemperature indication, forces all channels off |
| chan_on | output | 24 | Per-channel sink command, 1 = on |
| ser_out | output | 1 | Cascade output from stage 24 |

## Verification
The hardest case to reach is a two-device chain in which the second device's shift depends on the first device's falling-edge retiming. The bench drives two instances from shared control inputs and pushes 48 bits through them. It then compares both channel words against one 48-bit reference register. Hold behaviour is reached by dropping `latch_in` and shifting new data underneath it. Fault retention is reached by shifting data while a fault flag is set and then checking that the restored pattern matches the new contents.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int LSC_CHANNELS = 24;
  localparam int LSC_SYNC     = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_evt_t;

  // Any global condition that blanks every channel
  function automatic logic blank_all(input logic en_n, input logic uv, input logic ot);
    return en_n | uv | ot;
  endfunction

endpackage

// File: rtl/lsc_front.sv
module lsc_front #(
  parameter int SYNC_STAGES = lsc_pkg::LSC_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  output logic              core_rst_n,
  output lsc_pkg::sclk_evt_t evt
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   ser_clk_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  assign core_rst_n = rst_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ser_clk_q <= 1'b0;
    else             ser_clk_q <= ser_clk;
  end

  assign evt.rise = ser_clk & ~ser_clk_q;
  assign evt.fall = ~ser_clk & ser_clk_q;

endmodule

// File: rtl/lsc_shift.sv
module lsc_shift #(
  parameter int N = lsc_pkg::LSC_CHANNELS
) (
  input  logic         clk,
  input  logic         core_rst_n,
  input  logic         shift_en,
  input  logic         fall_en,
  input  logic         din,
  output logic [N-1:0] stage_q,
  output logic [N-1:0] stage_d,
  output logic         so
);

  // Stage 1 is bit 0, stage N is bit N-1
  function automatic logic [N-1:0] push_bit(input logic [N-1:0] w, input logic b);
    return {w[N-2:0], b};
  endfunction

  logic so_q;

  assign stage_d = shift_en ? push_bit(stage_q, din) : stage_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) stage_q <= '0;
    else             stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  so_q <= 1'b0;
    else if (fall_en) so_q <= stage_q[N-1];
  end

  assign so = so_q;

endmodule

// File: rtl/lsc_hold.sv
module lsc_hold #(
  parameter int N = lsc_pkg::LSC_CHANNELS
) (
  input  logic         clk,
  input  logic         core_rst_n,
  input  logic         latch_in,
  input  logic         en_n,
  input  logic         uv_flag,
  input  logic         ot_flag,
  input  logic [N-1:0] stage_q,
  input  logic [N-1:0] stage_d,
  output logic [N-1:0] chan_word,
  output logic [N-1:0] chan_on
);

  logic [N-1:0] hold_q;
  logic         kill;

  // Track next register value while transparent so a falling latch keeps the latest word
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   hold_q <= '0;
    else if (latch_in) hold_q <= stage_d;
  end

  assign chan_word = latch_in ? stage_q : hold_q;
  assign kill      = lsc_pkg::blank_all(en_n, uv_flag, ot_flag);

  for (genvar ch = 0; ch < N; ch++) begin : g_chan
    assign chan_on[ch] = chan_word[ch] & ~kill;
  end

endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl #(
  parameter int N           = lsc_pkg::LSC_CHANNELS,
  parameter int SYNC_STAGES = lsc_pkg::LSC_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_din,
  input  logic         latch_in,
  input  logic         en_n,
  input  logic         uv_flag,
  input  logic         ot_flag,
  output logic [N-1:0] chan_on,
  output logic         ser_out
);

  lsc_pkg::sclk_evt_t evt;
  logic               core_rst_n;
  logic               shift_evt;
  logic               fall_evt;
  logic [N-1:0]       stage_q;
  logic [N-1:0]       stage_d;
  logic [N-1:0]       chan_word;

  lsc_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .core_rst_n(core_rst_n),
    .evt       (evt)
  );

  assign shift_evt = evt.rise;
  assign fall_evt  = evt.fall;

  lsc_shift #(.N(N)) shift_i (
    .clk       (clk),
    .core_rst_n(core_rst_n),
    .shift_en  (shift_evt),
    .fall_en   (fall_evt),
    .din       (ser_din),
    .stage_q   (stage_q),
    .stage_d   (stage_d),
    .so        (ser_out)
  );

  lsc_hold #(.N(N)) hold_i (
    .clk       (clk),
    .core_rst_n(core_rst_n),
    .latch_in  (latch_in),
    .en_n      (en_n),
    .uv_flag   (uv_flag),
    .ot_flag   (ot_flag),
    .stage_q   (stage_q),
    .stage_d   (stage_d),
    .chan_word (chan_word),
    .chan_on   (chan_on)
  );

endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int N = lsc_pkg::LSC_CHANNELS
) (
  input logic         clk,
  input logic         rst_n,
  input logic         core_rst_n,
  input logic         ser_din,
  input logic         latch_in,
  input logic         en_n,
  input logic         uv_flag,
  input logic         ot_flag,
  input logic         shift_evt,
  input logic         fall_evt,
  input logic [N-1:0] stage_q,
  input logic [N-1:0] chan_word,
  input logic [N-1:0] chan_on,
  input logic         ser_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (chan_on == '0 && ser_out == 1'b0)); // R5
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!core_rst_n) shift_evt |=> stage_q[0] == $past(ser_din)); // R1
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!core_rst_n) shift_evt |=> stage_q[N-1:1] == $past(stage_q[N-2:0])); // R1
  AST_SO_FALL_ONLY: assert property (@(posedge clk) disable iff (!core_rst_n) !fall_evt |=> $stable(ser_out)); // R2
  AST_SO_TRACKS: assert property (@(posedge clk) disable iff (!core_rst_n) fall_evt |=> ser_out == $past(stage_q[N-1])); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!core_rst_n) (!latch_in && $past(!latch_in) && $past(core_rst_n)) |-> $stable(chan_word)); // R3
  AST_ENABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) en_n |-> chan_on == '0); // R4
  AST_UV_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) uv_flag |-> chan_on == '0); // R6
  AST_OT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n) ot_flag |-> chan_on == '0); // R7

endmodule

bind led_sink_ctrl lsc_chk #(.N(N)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_rst_n(core_rst_n),
  .ser_din   (ser_din),
  .latch_in  (latch_in),
  .en_n      (en_n),
  .uv_flag   (uv_flag),
  .ot_flag   (ot_flag),
  .shift_evt (shift_evt),
  .fall_evt  (fall_evt),
  .stage_q   (stage_q),
  .chan_word (chan_word),
  .chan_on   (chan_on),
  .ser_out   (ser_out)
);

// File: tb/led_sink_ctrl_tb_top.sv
`timescale 1ns/1ps
module led_sink_ctrl_tb_top;

  typedef struct {
    string      tag;
    int         sel;
    logic [23:0] exp;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic latch_in = 1'b1, en_n = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
  logic [23:0] a_on, b_on;
  logic so_a, so_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  sb_item_t sb_q[$];
  event sb_ev;

  // Reference: one 48-bit chain, bit 0 = first device stage 1
  logic [47:0] m48 = '0, hold48 = '0;
  logic so_m = 1'b0;

  always #2.5 clk = ~clk;

  led_sink_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .latch_in(latch_in), .en_n(en_n), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .chan_on(a_on), .ser_out(so_a));

  led_sink_ctrl dut_b (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(so_a),
    .latch_in(latch_in), .en_n(en_n), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .chan_on(b_on), .ser_out(so_b));

  function automatic logic [23:0] seen(input logic [23:0] w);
    if (en_n === 1'b1 || uv_flag === 1'b1 || ot_flag === 1'b1) return 24'h0;
    return w;
  endfunction

  // Monitor: pops expected items and compares with the outputs
  initial forever begin
    @(sb_ev);
    while (sb_q.size() != 0) begin
      sb_item_t it;
      logic [23:0] act;
      it = sb_q.pop_front();
      act = (it.sel == 0) ? a_on : (it.sel == 1) ? b_on : {23'b0, so_a};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(input string tag, input int sel, input logic [23:0] exp);
    sb_item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    ->sb_ev;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [47:0] vis;
    @(negedge clk); #1;
    vis = latch_in ? m48 : hold48;
    push(tag, 0, seen(vis[23:0]));
    push(tag, 1, seen(vis[47:24]));
    push(tag, 2, {23'b0, so_m});
  endtask

  task automatic ser_rise(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b1;
    tick(2);
    m48 = {m48[46:0], b};
    if (latch_in) hold48 = m48;
  endtask

  task automatic ser_fall();
    @(negedge clk); ser_clk = 1'b0;
    tick(2);
    so_m = m48[23];
  endtask

  task automatic shift_bit(input logic b);
    ser_rise(b);
    ser_fall();
  endtask

  task automatic shift_word(input logic [47:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic set_latch(input logic v);
    @(negedge clk); latch_in = v;
    if (v) hold48 = m48;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    m48 = '0; hold48 = '0; so_m = 1'b0;
    tick(2);
    check_all("R5 outputs cleared during reset");
    @(negedge clk); rst_n = 1'b1;
    tick(4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    tick(3);
    check_all("R5 reset state");
    @(negedge clk); rst_n = 1'b1;
    tick(4);

    // R9: single 1 lands in stage 1 = bit 0
    shift_bit(1'b1);
    check_all("R9 stage1 maps to bit0");
    // R1: three more shifts move it to bit 3
    shift_word(48'h0, 3);
    check_all("R1 bit moved to stage4");
    shift_word(48'hA5C31E, 24);
    check_all("R1 pattern loaded");

    // R2: stage 24 currently 1, stage 23 is 0
    ser_rise(1'b0);
    check_all("R2 ser_out unchanged on rise");
    ser_fall();
    check_all("R2 ser_out updated on fall");

    // R3: hold while latch low
    set_latch(1'b0);
    shift_word(48'hF0, 8);
    check_all("R3 outputs held while latch low");
    set_latch(1'b1);
    check_all("R3 transparent when latch high");

    // R4
    @(negedge clk); en_n = 1'b1;
    check_all("R4 enable high blanks");
    @(negedge clk); en_n = 1'b0;
    check_all("R4 enable low drives");

    // R6
    @(negedge clk); uv_flag = 1'b1;
    check_all("R6 undervoltage blanks");
    shift_word(48'h2, 2);
    check_all("R6 blanked while shifting");
    @(negedge clk); uv_flag = 1'b0;
    check_all("R6 data intact after undervoltage");

    // R7
    @(negedge clk); ot_flag = 1'b1;
    check_all("R7 overtemperature blanks");
    shift_word(48'h1, 2);
    @(negedge clk); ot_flag = 1'b0;
    check_all("R7 data intact after overtemperature");

    // R8: two-device chain
    do_reset();
    shift_word(48'hD2B46F1983CE, 48);
    check_all("R8 chain of two devices");

    // R5: reset mid-operation and first shift after release
    do_reset();
    check_all("R5 cleared after release");
    shift_bit(1'b1);
    check_all("R5 first shift after release");

    tick(4);
    finish_run();
  end

endmodule